// File: doc/BRIEF.md
# Multicycle Processor Step Controller

This block sequences a multicycle 32-bit load/store processor. A state register holds the current step. Combinational logic drives the datapath strobes for that step and picks the next step from the 6-bit opcode. Every instruction passes through a fetch step and then a decode/register-fetch step. After that, the path depends on the instruction class. A load takes five steps in all, a store and a register-register (R-type) operation take four, and a branch-on-equal or a jump takes three. The last step of each path returns to fetch.

The outputs are Moore outputs: each step asserts a fixed set of strobes, and any strobe that step does not use is held at 0. The ALU, register file, memory and the datapath registers lie outside this block. They obey the strobes: PC write enables, instruction and memory-data loads, memory read and write, register write, operand and write-back mux selects, and an ALU operation class.

Top module: `mcyc_ctrl`

## Requirements
- R1: When `rst` is 1 at a rising edge, the next step is fetch, whatever step was active.
- R2: Fetch sets pcWrite=1, memRead=1, irWrite=1, aluSrcB=2'b01 (constant 4), aluOp=2'b00 (add), pcSource=2'b00 (ALU result), and holds all other outputs at 0.
- R3: Decode always follows fetch. It sets aluSrcB=2'b11 (shifted immediate) and aluOp=2'b00, with all other outputs 0.
- R4: From decode, opcode 6'b000000 leads to an execute step (aluSrcA=1, aluSrcB=2'b00, aluOp=2'b10). A completion step follows (regWrite=1, regDst=1). Then fetch.
- R5: From decode, opcode 6'b100011 leads to an address step (aluSrcA=1, aluSrcB=2'b10, aluOp=2'b00). At the end of the address step, opcode 6'b100011 selects the read step (memRead=1, iorD=1). A write-back step follows (regWrite=1, memToReg=1). Then fetch.
- R6: From decode, opcode 6'b101011 also leads to the address step. At the end of that step, any opcode other than 6'b100011 selects the write step (memWrite=1, iorD=1), which returns to fetch.
- R7: From decode, opcode 6'b000100 leads to a branch step (aluSrcA=1, aluSrcB=2'b00, aluOp=2'b01, pcWriteCond=1, pcSource=2'b01), which returns to fetch.
- R8: From decode, opcode 6'b000010 leads to a jump step (pcWrite=1, pcSource=2'b10), which returns to fetch.
- R9: From decode, any opcode not listed in R4 to R8 returns straight to fetch.
- R10: The opcode is used only at the end of the decode and address steps. Changing it during any other step does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| pcWrite | output | 1 | Unconditional PC write |
| pcWriteCond | output | 1 | PC write when the ALU zero flag is set |
| iorD | output | 1 | Memory address select: 0 PC, 1 ALU output register |
| memRead | output | 1 | Memory read |
| memWrite | output | 1 | Memory write of register B |
| irWrite | output | 1 | Instruction register load |
| memToReg | output | 1 | Write-back source: 0 ALU output register, 1 memory data register |
| regDst | output | 1 | Destination field: 0 bits 20:16, 1 bits 15:11 |
| regWrite | output | 1 | Register file write |
| aluSrcA | output | 1 | ALU A operand: 0 PC, 1 register A |
| aluSrcB | output | 2 | ALU B operand: 00 B, 01 four, 10 sign-extended immediate, 11 immediate shifted by 2 |
| aluOp | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pcSource | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |

## Verification
No two steps drive the same strobe pattern, so a wrong step becomes visible at the ports in the same cycle it is entered. A wrong branch taken at decode or at the address step therefore shows up on the very next cycle. The reference model changes the opcode every cycle, which tests that only the two deciding steps react to it. Resets land at arbitrary points in the sequence, so a reset that fails to return to fetch from some step is also caught one cycle later.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_IMMS = 2'b11;

  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_OUTR = 2'b01;
  localparam logic [1:0] PCS_JMP  = 2'b10;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_RDMEM  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_WRMEM  = 4'd5,
    ST_REXEC  = 4'd6,
    ST_RDONE  = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_e;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       iorD;
    logic       memRead;
    logic       memWrite;
    logic       irWrite;
    logic       memToReg;
    logic       regDst;
    logic       regWrite;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] aluOp;
    logic [1:0] pcSource;
  } strobes_t;

endpackage

// File: rtl/mcyc_step_next.sv
module mcyc_step_next
  import mcyc_ctrl_pkg::*;
(
  input  step_e           curStep,
  input  logic [OP_W-1:0] opcode,
  output step_e           nextStep
);

  step_e afterDecode;
  step_e afterAddr;

  // dispatch on instruction class at the end of decode
  always_comb begin
    unique case (opcode)
      OP_RTYPE: afterDecode = ST_REXEC;
      OP_LOAD:  afterDecode = ST_ADDR;
      OP_STORE: afterDecode = ST_ADDR;
      OP_BEQ:   afterDecode = ST_BRANCH;
      OP_JUMP:  afterDecode = ST_JUMP;
      default:  afterDecode = ST_FETCH;
    endcase
  end

  // load reads memory; anything else leaving the address step writes it
  always_comb begin
    afterAddr = (opcode == OP_LOAD) ? ST_RDMEM : ST_WRMEM;
  end

  always_comb begin
    unique case (curStep)
      ST_FETCH:  nextStep = ST_DECODE;
      ST_DECODE: nextStep = afterDecode;
      ST_ADDR:   nextStep = afterAddr;
      ST_RDMEM:  nextStep = ST_LDWB;
      ST_REXEC:  nextStep = ST_RDONE;
      default:   nextStep = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_strobe_decode.sv
module mcyc_strobe_decode
  import mcyc_ctrl_pkg::*;
(
  input  step_e    curStep,
  output strobes_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (curStep)
      ST_FETCH: begin
        strobes.pcWrite  = 1'b1;
        strobes.memRead  = 1'b1;
        strobes.irWrite  = 1'b1;
        strobes.aluSrcB  = SRCB_FOUR;
        strobes.aluOp    = ALU_ADD;
        strobes.pcSource = PCS_ALU;
      end
      ST_DECODE: begin
        strobes.aluSrcB = SRCB_IMMS;
        strobes.aluOp   = ALU_ADD;
      end
      ST_ADDR: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = SRCB_IMM;
        strobes.aluOp   = ALU_ADD;
      end
      ST_RDMEM: begin
        strobes.memRead = 1'b1;
        strobes.iorD    = 1'b1;
      end
      ST_LDWB: begin
        strobes.regWrite = 1'b1;
        strobes.memToReg = 1'b1;
      end
      ST_WRMEM: begin
        strobes.memWrite = 1'b1;
        strobes.iorD     = 1'b1;
      end
      ST_REXEC: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = SRCB_REG;
        strobes.aluOp   = ALU_FUNC;
      end
      ST_RDONE: begin
        strobes.regWrite = 1'b1;
        strobes.regDst   = 1'b1;
      end
      ST_BRANCH: begin
        strobes.aluSrcA     = 1'b1;
        strobes.aluSrcB     = SRCB_REG;
        strobes.aluOp       = ALU_SUB;
        strobes.pcWriteCond = 1'b1;
        strobes.pcSource    = PCS_OUTR;
      end
      ST_JUMP: begin
        strobes.pcWrite  = 1'b1;
        strobes.pcSource = PCS_JMP;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            pcWrite,
  output logic            pcWriteCond,
  output logic            iorD,
  output logic            memRead,
  output logic            memWrite,
  output logic            irWrite,
  output logic            memToReg,
  output logic            regDst,
  output logic            regWrite,
  output logic            aluSrcA,
  output logic [1:0]      aluSrcB,
  output logic [1:0]      aluOp,
  output logic [1:0]      pcSource
);

  step_e    curStep;
  step_e    nextStep;
  strobes_t strobes;

  always_ff @(posedge clk) begin
    if (rst) curStep <= ST_FETCH;
    else     curStep <= nextStep;
  end

  mcyc_step_next u_next (
    .curStep  (curStep),
    .opcode   (opcode),
    .nextStep (nextStep)
  );

  mcyc_strobe_decode u_dec (
    .curStep (curStep),
    .strobes (strobes)
  );

  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign iorD        = strobes.iorD;
  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign irWrite     = strobes.irWrite;
  assign memToReg    = strobes.memToReg;
  assign regDst      = strobes.regDst;
  assign regWrite    = strobes.regWrite;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign aluOp       = strobes.aluOp;
  assign pcSource    = strobes.pcSource;

  // R3: an instruction load is always followed by the decode pattern
  p_decode_follows_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    irWrite |=> (aluSrcB == SRCB_IMMS && !aluSrcA && !irWrite));

  // R4: R-type execute is followed by a write to the rd field
  p_rtype_completes_r4: assert property (@(posedge clk) disable iff (rst)
    (aluOp == ALU_FUNC) |=> (regWrite && regDst && !memToReg));

  // R5: a data read is followed by write-back from the memory data register
  p_load_writeback_r5: assert property (@(posedge clk) disable iff (rst)
    (memRead && iorD) |=> (regWrite && memToReg && !regDst));

  // R6: a store returns to fetch
  p_store_returns_r6: assert property (@(posedge clk) disable iff (rst)
    memWrite |=> irWrite);

  // R7: the conditional PC write lasts one step and returns to fetch
  p_branch_returns_r7: assert property (@(posedge clk) disable iff (rst)
    pcWriteCond |=> (irWrite && !pcWriteCond));

  // R8: jump returns to fetch
  p_jump_returns_r8: assert property (@(posedge clk) disable iff (rst)
    (pcSource == PCS_JMP) |=> irWrite);

  // R5, R6: memory is never read and written in the same step
  p_mem_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

endmodule

// File: tb/mcyc_ctrl_tb.sv
module mcyc_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       pcWrite, pcWriteCond, iorD, memRead, memWrite, irWrite;
  logic       memToReg, regDst, regWrite, aluSrcA;
  logic [1:0] aluSrcB, aluOp, pcSource;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcyc_ctrl u_dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .iorD(iorD),
    .memRead(memRead), .memWrite(memWrite), .irWrite(irWrite),
    .memToReg(memToReg), .regDst(regDst), .regWrite(regWrite),
    .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp), .pcSource(pcSource)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  bit    mValid = 0;
  int    mStep = 0;
  string mTag = "R1";
  logic [5:0] prevOp = 6'd0;

  // expected 16-bit strobe vector per reference step number
  function automatic logic [15:0] expectVec(input int s);
    logic pw, pwc, iod, mr, mw, irw, m2r, rd, rw, sa;
    logic [1:0] sb, ao, ps;
    {pw, pwc, iod, mr, mw, irw, m2r, rd, rw, sa} = '0;
    sb = 2'b00; ao = 2'b00; ps = 2'b00;
    case (s)
      0: begin pw = 1; mr = 1; irw = 1; sb = 2'b01; end
      1: begin sb = 2'b11; end
      2: begin sa = 1; sb = 2'b10; end
      3: begin mr = 1; iod = 1; end
      4: begin rw = 1; m2r = 1; end
      5: begin mw = 1; iod = 1; end
      6: begin sa = 1; ao = 2'b10; end
      7: begin rw = 1; rd = 1; end
      8: begin sa = 1; ao = 2'b01; pwc = 1; ps = 2'b01; end
      9: begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {pw, pwc, iod, mr, mw, irw, m2r, rd, rw, sa, sb, ao, ps};
  endfunction

  function automatic string stepTag(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R5";
      5: return "R6";
      6, 7: return "R4";
      8: return "R7";
      default: return "R8";
    endcase
  endfunction

  // behavioural reference: step number advanced on every clock
  always @(posedge clk) begin
    int nxt;
    string tg;
    if (rst) begin
      mStep  <= 0;
      mTag   <= "R1";
      mValid <= 1'b1;
    end else if (mValid) begin
      case (mStep)
        0: nxt = 1;
        1: begin
          if (opcode == 6'h00) nxt = 6;
          else if (opcode == 6'h23 || opcode == 6'h2b) nxt = 2;
          else if (opcode == 6'h04) nxt = 8;
          else if (opcode == 6'h02) nxt = 9;
          else nxt = 0;
        end
        2: nxt = (opcode == 6'h23) ? 3 : 5;
        3: nxt = 4;
        6: nxt = 7;
        default: nxt = 0;
      endcase
      tg = stepTag(nxt);
      if (mStep == 1 && nxt == 0) tg = "R9";
      else if (mStep != 1 && mStep != 2 && opcode != prevOp) tg = "R10";
      mStep <= nxt;
      mTag  <= tg;
    end
    prevOp <= opcode;
  end

  // compare away from the active edge
  always @(negedge clk) begin
    logic [15:0] act, exp;
    if (mValid && !done) begin
      act = {pcWrite, pcWriteCond, iorD, memRead, memWrite, irWrite, memToReg,
             regDst, regWrite, aluSrcA, aluSrcB, aluOp, pcSource};
      exp = expectVec(mStep);
      total++;
      if (act !== exp) begin
        bad++;
        $display("FAIL %s step=%0d actual=%b expected=%b", mTag, mStep, act, exp);
      end
    end
  end

  function automatic logic [5:0] pickOp(input int r);
    case (r % 8)
      0: return 6'h00;
      1: return 6'h23;
      2: return 6'h2b;
      3: return 6'h04;
      4: return 6'h02;
      5: return 6'h3f;
      6: return 6'h23;
      default: return 6'h11;
    endcase
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // directed pass: hold each class for a full path (R4..R9)
    for (int k = 0; k < 6; k++) begin
      opcode = pickOp(k == 5 ? 5 : k);
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
    end
    // random opcode every cycle, with resets at scattered points (R1, R10)
    for (int c = 0; c < 600; c++) begin
      opcode = pickOp(int'($urandom));
      rst = (c % 97 == 50) || (c % 131 == 77);
      @(negedge clk);
    end
    rst = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule